// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counter

This block lives in the instruction fetch stage. It turns the current fetch address into a predicted next fetch address within the same cycle. It holds a small direct-mapped table of recently seen branches. Each slot keeps four things: an occupancy flag, the upper address bits of the branch that owns it, that branch's last taken destination, and a two-bit saturating direction counter.

The lookup is purely combinational. A slot is selected by the fetch address, and its owner bits are compared against the fetch address. When the owner matches and the counter leans toward taken, the stored destination is offered as the next address. In every other case the sequential address (fetch address plus four) is offered.

When a branch resolves later in the pipeline, its address, outcome and actual destination arrive on a one-cycle update strobe. That update adjusts the counter of a matching slot, or claims a slot for a taken branch that was not present. The change becomes visible after the next rising clock edge. Because the counter needs two consecutive wrong guesses to leave a strong state, a loop-closing branch costs one wrong guess per loop run.

Top module: `btb_predictor`

## Requirements
- R1: When the selected slot is occupied, its owner bits equal fetch_pc[31:6], and its counter has bit 1 set (value 2'b10 or 2'b11), pred_taken is 1 and pred_next_pc equals the stored destination.
- R2: In every other case pred_taken is 0 and pred_next_pc equals fetch_pc + 4.
- R3: The slot is selected by fetch_pc[5:2], giving 16 slots. pred_hit is 1 only when that slot is occupied and its owner bits match fetch_pc[31:6]. pred_taken is never 1 without pred_hit.
- R4: Two addresses with the same bits [5:2] but different upper bits share one slot. A lookup of the non-owner misses, and claiming the slot for one branch evicts the other.
- R5: The counter encoding is 2'b00 and 2'b01 for not taken, 2'b10 and 2'b11 for taken. On an update that matches the slot owner, the counter steps up by one on a taken outcome and down by one on a not-taken outcome, saturating at 2'b11 and 2'b00. From 2'b11 a single not-taken outcome still predicts taken.
- R6: A branch taken on three iterations and not taken on the fourth, run twice, is guessed wrong twice on the first run (first sighting and exit) and exactly once on the second run.
- R7: A taken update for an address whose slot does not match claims the slot: occupancy set, owner bits and destination written, counter set to 2'b10.
- R8: A not-taken update for an address whose slot does not match leaves the table unchanged.
- R9: While rst_n is low, every slot is emptied, so every lookup after reset misses.
- R10: A taken update that matches the owner overwrites the stored destination with upd_target. A not-taken update that matches leaves the destination unchanged.
- R11: An update changes the table at the rising edge that samples it. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| fetch_pc | input | 32 | Address currently being fetched |
| pred_hit | output | 1 | The selected slot is owned by fetch_pc |
| pred_taken | output | 1 | The prediction is taken |
| pred_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | 32 | Resolved destination of the branch |

## Verification
The assertions check the following on every cycle:
- the sequential fall-through address whenever the prediction is not taken;
- that a taken prediction always implies a hit;
- the empty table after reset;
- the exact slot contents after each kind of update: a counter step on a match, a claim with the weak-taken value, no change for a not-taken miss, and destination rewriting.

Some behaviour only the bench scenarios can show. These are the hysteresis sequences across several updates, the one-wrong-guess-per-run loop property, and eviction between aliasing addresses. The same-cycle visibility of an update also needs a scenario, since each of these spans several updates or a particular timing of lookup against update.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int unsigned PC_W    = 32;
    localparam int unsigned IDX_W   = 4;
    localparam int unsigned ALIGN_W = 2;
    localparam int unsigned CTR_W   = 2;
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_W   = PC_W - IDX_W - ALIGN_W;

    typedef logic [CTR_W-1:0] ctr_t;
    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;

    localparam ctr_t CTR_WEAK_TAKEN = ctr_t'(1 << (CTR_W - 1));
    localparam pc_t  PC_STEP        = pc_t'(1 << ALIGN_W);

    typedef struct packed {
        logic valid;
        tag_t tag;
        pc_t  target;
        ctr_t ctr;
    } entry_t;

    typedef entry_t [ENTRIES-1:0] table_t;

    function automatic idx_t pc_index(input pc_t pc);
        return pc[ALIGN_W +: IDX_W];
    endfunction

    function automatic tag_t pc_tag(input pc_t pc);
        return pc[PC_W-1 -: TAG_W];
    endfunction

    function automatic logic leans_taken(input ctr_t c);
        return c[CTR_W-1];
    endfunction

endpackage

// File: rtl/btb_sat_counter.sv
module btb_sat_counter #(
    parameter int unsigned W = 2
) (
    input  logic [W-1:0] cur,
    input  logic         taken,
    output logic [W-1:0] nxt
);

    always_comb begin
        if (taken) begin
            nxt = (&cur) ? cur : cur + 1'b1;
        end else begin
            nxt = (|cur) ? cur - 1'b1 : cur;
        end
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
(
    input  table_t tbl,
    input  pc_t    pc,
    output logic   hit,
    output logic   taken,
    output pc_t    next_pc
);

    entry_t sel;

    always_comb begin
        sel     = tbl[pc_index(pc)];
        hit     = sel.valid && (sel.tag == pc_tag(pc));
        taken   = hit && leans_taken(sel.ctr);
        next_pc = taken ? sel.target : pc + PC_STEP;
    end

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
(
    input  table_t cur,
    input  logic   upd_valid,
    input  pc_t    upd_pc,
    input  logic   upd_taken,
    input  pc_t    upd_target,
    output table_t nxt
);

    idx_t upd_idx;
    tag_t upd_tag;

    always_comb begin
        upd_idx = pc_index(upd_pc);
        upd_tag = pc_tag(upd_pc);
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        ctr_t   ctr_step;
        entry_t ent_n;
        logic   sel;
        logic   owned;

        btb_sat_counter #(.W(CTR_W)) u_ctr (
            .cur   (cur[i].ctr),
            .taken (upd_taken),
            .nxt   (ctr_step)
        );

        always_comb begin
            sel   = upd_valid && (upd_idx == IDX_W'(i));
            owned = cur[i].valid && (cur[i].tag == upd_tag);
            ent_n = cur[i];
            if (sel) begin
                if (owned) begin
                    ent_n.ctr = ctr_step;
                    if (upd_taken) begin
                        ent_n.target = upd_target;
                    end
                end else if (upd_taken) begin
                    ent_n.valid  = 1'b1;
                    ent_n.tag    = upd_tag;
                    ent_n.target = upd_target;
                    ent_n.ctr    = CTR_WEAK_TAKEN;
                end
            end
        end

        assign nxt[i] = ent_n;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] pred_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    typedef struct packed {
        table_t tbl;
    } state_t;

    state_t st_d;
    state_t st_q;
    table_t table_q;
    table_t table_upd;

    assign table_q = st_q.tbl;

    btb_lookup u_lookup (
        .tbl     (table_q),
        .pc      (fetch_pc),
        .hit     (pred_hit),
        .taken   (pred_taken),
        .next_pc (pred_next_pc)
    );

    btb_update u_update (
        .cur        (table_q),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_target (upd_target),
        .nxt        (table_upd)
    );

    always_comb begin
        st_d     = st_q;
        st_d.tbl = table_upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/btb_checker.sv
module btb_checker
    import btb_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input pc_t    fetch_pc,
    input logic   pred_hit,
    input logic   pred_taken,
    input pc_t    pred_next_pc,
    input logic   upd_valid,
    input pc_t    upd_pc,
    input logic   upd_taken,
    input pc_t    upd_target,
    input table_t table_q
);

    typedef enum logic [1:0] {K_NONE, K_MATCH, K_CLAIM, K_DROP} kind_t;

    entry_t at_upd;
    logic   upd_match;
    kind_t  kind_now;
    logic [ENTRIES-1:0] occupied;

    kind_t  kind_q;
    idx_t   idx_q;
    entry_t before_q;
    logic   taken_q;
    pc_t    target_q;
    pc_t    pc_q;
    entry_t after;

    always_comb begin
        at_upd    = table_q[pc_index(upd_pc)];
        upd_match = at_upd.valid && (at_upd.tag == pc_tag(upd_pc));
        if (!upd_valid)     kind_now = K_NONE;
        else if (upd_match) kind_now = K_MATCH;
        else if (upd_taken) kind_now = K_CLAIM;
        else                kind_now = K_DROP;
        for (int i = 0; i < ENTRIES; i++) begin
            occupied[i] = table_q[i].valid;
        end
        after = table_q[idx_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_NONE;
            idx_q    <= '0;
            before_q <= '0;
            taken_q  <= 1'b0;
            target_q <= '0;
            pc_q     <= '0;
        end else begin
            kind_q   <= kind_now;
            idx_q    <= pc_index(upd_pc);
            before_q <= at_upd;
            taken_q  <= upd_taken;
            target_q <= upd_target;
            pc_q     <= upd_pc;
        end
    end

    // R2
    assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_next_pc == fetch_pc + PC_STEP));

    // R3
    assert_taken_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R9
    assert_reset_empties_R9: assert property (@(posedge clk)
        !rst_n |=> (occupied == '0));

    // R7
    assert_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_CLAIM) |-> (after.valid && after.tag == pc_tag(pc_q)
                                 && after.target == target_q
                                 && after.ctr == CTR_WEAK_TAKEN));

    // R8
    assert_no_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_DROP) |-> (after == before_q));

    // R5
    assert_counter_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_MATCH) |-> (taken_q
            ? ((after.ctr == ctr_t'(before_q.ctr + 1'b1)) || ((&before_q.ctr) && (&after.ctr)))
            : ((after.ctr == ctr_t'(before_q.ctr - 1'b1)) || ((~|before_q.ctr) && (~|after.ctr)))));

    // R10
    assert_target_refresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_q == K_MATCH) |-> (after.target == (taken_q ? target_q : before_q.target)));

endmodule

bind btb_predictor btb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_pc     (fetch_pc),
    .pred_hit     (pred_hit),
    .pred_taken   (pred_taken),
    .pred_next_pc (pred_next_pc),
    .upd_valid    (upd_valid),
    .upd_pc       (upd_pc),
    .upd_taken    (upd_taken),
    .upd_target   (upd_target),
    .table_q      (table_q)
);

// File: tb/btb_predictor_test.sv
module btb_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] pc;
        logic        hit;
        logic        taken;
        logic [31:0] next;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    btb_predictor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_pc     (fetch_pc),
        .pred_hit     (pred_hit),
        .pred_taken   (pred_taken),
        .pred_next_pc (pred_next_pc),
        .upd_valid    (upd_valid),
        .upd_pc       (upd_pc),
        .upd_taken    (upd_taken),
        .upd_target   (upd_target)
    );

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops one expectation per cycle and compares with the outputs.
    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check_val({e.req, " hit/taken"}, {30'd0, pred_hit, pred_taken}, {30'd0, e.hit, e.taken});
                check_val({e.req, " next_pc"}, pred_next_pc, e.next);
            end
        end
    end

    function automatic exp_t mk(input logic [31:0] pc, input logic hit, input logic taken,
                                input logic [31:0] next, input string req);
        exp_t e;
        e.pc = pc; e.hit = hit; e.taken = taken; e.next = next; e.req = req;
        return e;
    endfunction

    task automatic expect_fetch(input logic [31:0] pc, input logic hit, input logic taken,
                                input logic [31:0] next, input string req);
        @(posedge clk); #1;
        fetch_pc = pc;
        sb_q.push_back(mk(pc, hit, taken, next, req));
        @(negedge clk); #1;
    endtask

    task automatic do_update(input logic [31:0] pc, input logic taken, input logic [31:0] tgt);
        @(posedge clk); #1;
        upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic loop_run(input logic [31:0] pc, input logic [31:0] tgt, output int wrong);
        wrong = 0;
        for (int k = 0; k < 4; k++) begin
            logic outcome;
            logic guess;
            outcome = (k < 3);
            @(posedge clk); #1;
            fetch_pc = pc;
            @(negedge clk);
            guess = pred_taken;
            if (guess != outcome) wrong++;
            do_update(pc, outcome, tgt);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int wrong;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: empty after reset
        expect_fetch(32'h100, 1'b0, 1'b0, 32'h104, "R9 reset empty");
        // R8: not-taken miss does not claim
        do_update(32'h100, 1'b0, 32'h200);
        expect_fetch(32'h100, 1'b0, 1'b0, 32'h104, "R8 no claim");
        // R7 / R1: taken miss claims at 2'b10, predicts stored target
        do_update(32'h100, 1'b1, 32'h200);
        expect_fetch(32'h100, 1'b1, 1'b1, 32'h200, "R7 R1 claim weak taken");
        // R5: weak taken -> 01 not taken
        do_update(32'h100, 1'b0, 32'h0);
        expect_fetch(32'h100, 1'b1, 1'b0, 32'h104, "R5 weak flips");
        do_update(32'h100, 1'b1, 32'h200);
        do_update(32'h100, 1'b1, 32'h200);
        do_update(32'h100, 1'b1, 32'h200);
        do_update(32'h100, 1'b0, 32'h0);
        expect_fetch(32'h100, 1'b1, 1'b1, 32'h200, "R5 strong survives one miss");
        do_update(32'h100, 1'b0, 32'h0);
        expect_fetch(32'h100, 1'b1, 1'b0, 32'h104, "R5 second miss flips");
        do_update(32'h100, 1'b0, 32'h0);
        do_update(32'h100, 1'b0, 32'h0);
        do_update(32'h100, 1'b1, 32'h200);
        expect_fetch(32'h100, 1'b1, 1'b0, 32'h104, "R5 low saturation");
        do_update(32'h100, 1'b1, 32'h200);
        expect_fetch(32'h100, 1'b1, 1'b1, 32'h200, "R5 back to taken");

        // R4: alias with same index, other upper bits
        expect_fetch(32'h140, 1'b0, 1'b0, 32'h144, "R4 alias misses");

        // R6: loop branch
        loop_run(32'h140, 32'h120, wrong);
        check_val("R6 first run wrong guesses", 32'(wrong), 32'd2);
        loop_run(32'h140, 32'h120, wrong);
        check_val("R6 second run wrong guesses", 32'(wrong), 32'd1);

        expect_fetch(32'h100, 1'b0, 1'b0, 32'h104, "R4 evicted");
        expect_fetch(32'h140, 1'b1, 1'b1, 32'h120, "R4 new owner");

        // R10: target refresh on taken match, kept on not-taken match
        do_update(32'h140, 1'b1, 32'h300);
        expect_fetch(32'h140, 1'b1, 1'b1, 32'h300, "R10 target rewritten");
        do_update(32'h140, 1'b0, 32'h999);
        expect_fetch(32'h140, 1'b1, 1'b1, 32'h300, "R10 target kept");

        // R3: index 15 and tag compare
        do_update(32'h3C, 1'b1, 32'h80);
        expect_fetch(32'h3C, 1'b1, 1'b1, 32'h80, "R3 last slot");
        expect_fetch(32'h7C, 1'b0, 1'b0, 32'h80, "R3 tag mismatch");
        expect_fetch(32'h38, 1'b0, 1'b0, 32'h3C, "R3 neighbour slot");

        // R11: same-cycle lookup sees old contents
        @(posedge clk); #1;
        upd_valid = 1'b1; upd_pc = 32'h3C; upd_taken = 1'b0; upd_target = 32'h0;
        fetch_pc = 32'h3C;
        sb_q.push_back(mk(32'h3C, 1'b1, 1'b1, 32'h80, "R11 old in update cycle"));
        @(negedge clk);
        @(posedge clk); #1;
        upd_valid = 1'b0;
        sb_q.push_back(mk(32'h3C, 1'b1, 1'b0, 32'h40, "R11 new after edge"));
        @(negedge clk); #1;

        // R9: reset mid-run
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        expect_fetch(32'h140, 1'b0, 1'b0, 32'h144, "R9 reset again");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule